// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Unit

A multiply-accumulate datapath built around one 32x16 multiplier array. The array is made of two 16-bit sub-multipliers that see the same second-operand slice in the 32x16 and 32x32 modes, which gives a 48-bit partial product. In dual mode they see different slices, and the two 16x16 products are summed in the same cycle. A 32x32 multiply reuses the array over two passes. The first pass uses the low half of the second operand. The second pass uses the high half, and its partial product is shifted up by half a word before it is added.

The accumulator arrives on its own 64-bit port, apart from the two multiplicand ports. When the operation requests it, the accumulator is added to the product modulo 2^64. The two operand registers are loaded only when a two-pass operation is accepted. At all other times they hold their value, and so does the result register between operations.

Top module: `dual_mac`

## Requirements
- R1: After reset, `out_valid` and `busy` are 0 and `result` is 0.
- R2: Operation kind `op[1:0]=0` (half x half) gives `a[15:0]*b[15:0]`. The result appears with `out_valid=1` in the cycle after the accepting edge.
- R3: Operation kind `op[1:0]=1` (word x half) gives `a[31:0]*b[15:0]`, with the same one-cycle timing.
- R4: Operation kind `op[1:0]=2` (word x word) gives `a*b`. `busy=1` and `out_valid=0` in the cycle after acceptance, and the result comes with `out_valid=1` in the cycle after that.
- R5: Operation kind `op[1:0]=3` (dual) gives `a[15:0]*b[15:0] + a[31:16]*b[31:16]` in one pass.
- R6: When `op[2]=1`, `acc_in` is added to the product modulo 2^64 with no saturation. When `op[2]=0`, `acc_in` has no effect.
- R7: `a_signed` and `b_signed` select two's-complement or unsigned reading of every slice taken from `a` and `b`, respectively.
- R8: `in_valid` is ignored while `busy=1`. No extra `out_valid` follows, and the pending result is not altered.
- R9: `result` holds its value in every cycle in which no operation completes, and `out_valid` is 0 in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Start an operation (taken when not busy) |
| op | input | 3 | [1:0] kind, [2] accumulate enable |
| a | input | 32 | First multiplicand |
| b | input | 32 | Second multiplicand |
| acc_in | input | 64 | Accumulate operand, dedicated port |
| a_signed | input | 1 | Read `a` slices as signed |
| b_signed | input | 1 | Read `b` slices as signed |
| busy | output | 1 | Second pass of a word x word operation in progress |
| out_valid | output | 1 | Done strobe, one cycle |
| result | output | 64 | Product plus optional accumulator |

## Verification
The bench builds the unit with its default operand width of 32. At that width a 64-bit integer reference model can compute every mode exactly, including the wraparound of the accumulate. This makes the most negative value, all-ones operands and mixed signedness reachable as directed cases next to a few hundred random operations. Operations are also issued during the busy cycle, so the ignore rule and the hold of the result are observed at the ports.

// File: rtl/dual_mac.sv
module dual_mac #(
  parameter int OP_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          op,
  input  logic [OP_W-1:0]     a,
  input  logic [OP_W-1:0]     b,
  input  logic [2*OP_W-1:0]   acc_in,
  input  logic                a_signed,
  input  logic                b_signed,
  output logic                busy,
  output logic                out_valid,
  output logic [2*OP_W-1:0]   result
);
  localparam int H   = OP_W / 2;
  localparam int R_W = 2 * OP_W;
  localparam int P_W = 2 * (H + 1);
  localparam logic [1:0] K_HH = 2'd0, K_WH = 2'd1, K_WW = 2'd2, K_DUAL = 2'd3;

  logic [OP_W-1:0] a_q;
  logic [H-1:0]    bh_q;
  logic            sa_q, sb_q;
  logic [R_W-1:0]  part_q;

  wire [1:0] kind   = op[1:0];
  wire       accept = in_valid & ~busy;
  wire       half_x = (kind == K_HH) || (kind == K_DUAL);

  wire [OP_W-1:0] xs  = busy ? a_q : a;
  wire            xsg = busy ? sa_q : a_signed;

  logic signed [H:0] xl, xh, yl, yh;
  assign xl = {~busy & half_x & a_signed & a[H-1], xs[H-1:0]};
  assign xh = {xsg & xs[OP_W-1], xs[OP_W-1:H]};
  assign yl = busy ? {sb_q & bh_q[H-1], bh_q}
            : (kind == K_WW) ? {1'b0, b[H-1:0]}
            : {b_signed & b[H-1], b[H-1:0]};
  assign yh = (!busy && kind == K_DUAL) ? {b_signed & b[OP_W-1], b[OP_W-1:H]} : yl;

  logic signed [P_W-1:0] pl, ph;
  assign pl = P_W'(xl) * P_W'(yl);
  assign ph = P_W'(xh) * P_W'(yh);

  wire [R_W-1:0] el = {{(R_W-P_W){pl[P_W-1]}}, pl};
  wire [R_W-1:0] eh = {{(R_W-P_W){ph[P_W-1]}}, ph};

  logic [R_W-1:0] prod, sum;
  always_comb begin
    if (!busy && kind == K_HH)        prod = el;
    else if (!busy && kind == K_DUAL) prod = el + eh;
    else                              prod = (eh << H) + el;
    if (busy) sum = part_q + (prod << H);
    else      sum = prod + (op[2] ? acc_in : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      result    <= '0;
      a_q       <= '0;
      bh_q      <= '0;
      sa_q      <= 1'b0;
      sb_q      <= 1'b0;
      part_q    <= '0;
    end else if (accept && kind == K_WW) begin
      busy      <= 1'b1;
      out_valid <= 1'b0;
      a_q       <= a;
      bh_q      <= b[OP_W-1:H];
      sa_q      <= a_signed;
      sb_q      <= b_signed;
      part_q    <= sum;
    end else if (accept || busy) begin
      busy      <= 1'b0;
      out_valid <= 1'b1;
      result    <= sum;
    end else begin
      out_valid <= 1'b0;
    end
  end

  // R2
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && op[1:0] != K_WW) |=> (out_valid && !busy));
  // R4
  wide_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && op[1:0] == K_WW) |=> (busy && !out_valid));
  // R4
  wide_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (out_valid && !busy));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(bh_q) && $stable(part_q)));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_valid) |=> ($stable(result) && !out_valid));
endmodule

// File: tb/dual_mac_test.sv
`timescale 1ns/1ps
module dual_mac_test;
  logic clk = 0, rst_n = 0, in_valid = 0, a_signed = 0, b_signed = 0;
  logic [2:0] op = 0;
  logic [31:0] a = 0, b = 0;
  logic [63:0] acc_in = 0;
  logic busy, out_valid;
  logic [63:0] result;
  int tests = 0, fails = 0;

  dual_mac uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .acc_in(acc_in), .a_signed(a_signed), .b_signed(b_signed), .busy(busy),
    .out_valid(out_valid), .result(result));

  always #2 clk = ~clk;

  function automatic logic [63:0] ext(logic [31:0] v, int w, bit s);
    logic [63:0] r = 0;
    for (int i = 0; i < 64; i++) r[i] = (i < w) ? v[i] : (s & v[w-1]);
    return r;
  endfunction

  function automatic logic [63:0] ref_mac(logic [2:0] o, logic [31:0] x, logic [31:0] y,
                                          logic [63:0] c, bit sx, bit sy);
    logic [63:0] p;
    case (o[1:0])
      2'd0: p = ext(x, 16, sx) * ext(y, 16, sy);
      2'd1: p = ext(x, 32, sx) * ext(y, 16, sy);
      2'd2: p = ext(x, 32, sx) * ext(y, 32, sy);
      default: p = ext(x, 16, sx) * ext(y, 16, sy)
                 + ext({16'h0, x[31:16]}, 16, sx) * ext({16'h0, y[31:16]}, 16, sy);
    endcase
    return o[2] ? p + c : p;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one operation; inputs driven at negedge, outputs sampled at negedge
  task automatic run(logic [2:0] o, logic [31:0] x, logic [31:0] y, logic [63:0] c,
                     bit sx, bit sy, bit poke);
    logic [63:0] exp = ref_mac(o, x, y, c, sx, sy);
    string tag;
    case (o[1:0])
      2'd0: tag = "R2"; 2'd1: tag = "R3"; 2'd2: tag = "R4"; default: tag = "R5";
    endcase
    if (o[2]) tag = {tag, "/R6"};
    if (sx | sy) tag = {tag, "/R7"};
    op = o; a = x; b = y; acc_in = c; a_signed = sx; b_signed = sy; in_valid = 1;
    @(negedge clk);
    if (o[1:0] == 2'd2) begin
      check("R4 busy", {63'h0, busy}, 64'd1);
      check("R4 no early done", {63'h0, out_valid}, 64'd0);
      in_valid = poke;
      op = 3'd4; a = ~x; b = ~y; acc_in = ~c; a_signed = ~sx; b_signed = ~sy;
      @(negedge clk);
    end
    in_valid = 0;
    check({tag, " done"}, {63'h0, out_valid}, 64'd1);
    check(tag, result, exp);
    acc_in = ~acc_in; a = ~a;
    @(negedge clk);
    check(poke ? "R8 ignored" : "R9 strobe", {63'h0, out_valid}, 64'd0);
    check("R9 hold", result, exp);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 out_valid", {63'h0, out_valid}, 64'd0);
    check("R1 busy", {63'h0, busy}, 64'd0);
    check("R1 result", result, 64'd0);
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 4; s++) begin
        run(3'(m), 32'h8000_0000, 32'h8000_8000, 64'hFFFF_FFFF_FFFF_FFFF, s[0], s[1], 1'b0);
        run(3'(m), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h8000_0000_0000_0000, s[0], s[1], 1'b1);
        run(3'(m), 32'h7FFF_8000, 32'h8000_7FFF, 64'h0123_4567_89AB_CDEF, s[0], s[1], 1'b0);
      end
    end
    for (int i = 0; i < 300; i++)
      run(3'($urandom), $urandom, $urandom, {$urandom, $urandom},
          1'($urandom), 1'($urandom), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule